// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Link

This block is a three-wire serial master for small display controllers that take 9-bit words. The top bit of every word tells the controller whether the low eight bits are a command or a parameter. A client gives one request at a time over a valid/ready handshake. A request is either a single command word, a single parameter word, a register read of a chosen length, or an identification check. Each request produces one completion strobe.

A read sends one command word. In the same select window the data pin is then turned around, and the controller answers with nine serial clocks per requested byte. The answer begins with one dummy bit, so its bytes do not line up with the 9-bit word boundaries. The block stores the received words and repacks them into clean bytes. The identification check is a three-byte read that is compared against a fixed signature. A mode input can switch reads off altogether. When reads are off, the identification check reports success without any bus traffic.

The clock divider is a parameter. The serial clock idles low. Data is launched after a falling edge and captured on the rising edge, most significant bit first.

Top module: `nine_bit_panel_link`

## Requirements
- R1: A write request sends exactly one 9-bit word in its own select window, most significant bit first. Bit 8 is the low bit of `req_kind` (0 for a command, kind 2'b00; 1 for a parameter, kind 2'b01), and bits 7..0 are `req_byte`.
- R2: The serial clock is low whenever select is high. Every half period lasts `DIV_HALF` system cycles. `sd_out` changes only while the serial clock is low.
- R3: A read (kind 2'b10) sends the command word `{0, req_byte}` and then gives 9 x `req_len` further serial clocks in the same select window. `sd_oe` falls after the ninth clock and stays low until select rises.
- R4: The first received bit is a dummy and is dropped. Byte k of the reply is made of received bits 1+8k to 8+8k, most significant bit first. It appears on `rd_data[8k+7:8k]`, and bytes at or above the read length read as zero.
- R5: A read length other than 1, 3 or 4 sets `err` with the completion strobe and causes no select activity.
- R6: An identification check (kind 2'b11) reads three bytes after command 0x04. `id_ok` is 1 only when bytes 0, 1 and 2 are 0x85, 0x85 and 0x52.
- R7: With `reads_off` high, an identification check completes with `id_ok` = 1 and `err` = 0, and a read completes with `err` = 1. Neither one lowers select.
- R8: `req_ready` is low from acceptance until the completion strobe, and `done` lasts one cycle. Select stays high for at least 2 x `DIV_HALF` cycles between windows.
- R9: After reset, select is high, the serial clock is low, `req_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Link idle, request taken when valid |
| req_kind | input | 2 | 00 command, 01 parameter, 10 read, 11 identification check |
| req_byte | input | 8 | Command or parameter byte |
| req_len | input | 3 | Read length in bytes |
| reads_off | input | 1 | Receive path unavailable |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| sd_out | output | 1 | Serial data to the panel |
| sd_oe | output | 1 | Output enable of the shared data pad |
| sd_in | input | 1 | Serial data from the panel |
| rd_data | output | 32 | Realigned reply, byte 0 lowest |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Last request was rejected |
| id_ok | output | 1 | Last identification check matched |

## Verification
The completion strobe of one transaction and the next pending request can fall in the same cycle. The bench keeps `req_valid` asserted for a whole write and lowers it only in the cycle where `done` is seen. It then checks that exactly one select window opened and that `req_ready` never rose while select was low. A second pair of requests is issued back to back, and the shortest select-high gap measured at the pins must still reach two serial half periods. Reply streams are built from the byte list with the dummy bit set to 1, so a failure to drop that bit shows up in the comparison.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  localparam int RX_BYTES = 4;
  localparam int WORD_W   = 9;

  typedef enum logic [1:0] {
    K_CMD  = 2'b00,
    K_DAT  = 2'b01,
    K_READ = 2'b10,
    K_ID   = 2'b11
  } req_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SHIFT,
    S_GAP,
    S_FIN
  } link_state_e;

  function automatic logic len_legal(input logic [2:0] n);
    return (n == 3'd1) || (n == 3'd3) || (n == 3'd4);
  endfunction
endpackage

// File: rtl/nbl_tick.sv
module nbl_tick #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(DIV_HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nbl_rx_capture.sv
module nbl_rx_capture
  import nbl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       en,
  input  logic                       sd_in,
  output logic [WORD_W*RX_BYTES-1:0] words
);
  localparam int IW = $clog2(RX_BYTES + 1);

  logic [WORD_W-1:0] w_q [RX_BYTES];
  logic [WORD_W-1:0] w_d [RX_BYTES];
  logic [IW-1:0]     idx_q, idx_d;
  logic [3:0]        pos_q, pos_d;

  always_comb begin
    w_d   = w_q;
    idx_d = idx_q;
    pos_d = pos_q;
    if (clear) begin
      for (int k = 0; k < RX_BYTES; k++) w_d[k] = '0;
      idx_d = '0;
      pos_d = '0;
    end else if (en) begin
      for (int k = 0; k < RX_BYTES; k++)
        if (idx_q == IW'(k)) w_d[k] = {w_q[k][WORD_W-2:0], sd_in};
      if (pos_q == 4'(WORD_W - 1)) begin
        pos_d = '0;
        idx_d = idx_q + 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < RX_BYTES; k++) w_q[k] <= '0;
      idx_q <= '0;
      pos_q <= '0;
    end else begin
      w_q   <= w_d;
      idx_q <= idx_d;
      pos_q <= pos_d;
    end
  end

  for (genvar g = 0; g < RX_BYTES; g++) begin : g_flat
    assign words[WORD_W*g +: WORD_W] = w_q[g];
  end
endmodule

// File: rtl/nbl_rx_align.sv
module nbl_rx_align
  import nbl_pkg::*;
(
  input  logic [WORD_W*RX_BYTES-1:0] words,
  input  logic [2:0]                 len,
  output logic [8*RX_BYTES-1:0]      bytes
);
  logic [RX_BYTES-1:0][2*WORD_W-1:0] pair;
  logic unused_pair;

  for (genvar g = 0; g < RX_BYTES; g++) begin : g_byte
    if (g == 0) begin : g_first
      assign pair[g] = {{WORD_W{1'b0}}, words[0 +: WORD_W]};
    end else begin : g_rest
      assign pair[g] = {words[WORD_W*(g-1) +: WORD_W], words[WORD_W*g +: WORD_W]};
    end
    assign bytes[8*g +: 8] = (3'(g) < len) ? pair[g][g+7:g] : 8'h00;
  end

  assign unused_pair = ^pair;
endmodule

// File: rtl/nbl_ctrl.sv
module nbl_ctrl
  import nbl_pkg::*;
#(
  parameter logic [7:0]  ID_CMD    = 8'h04,
  parameter logic [23:0] ID_EXPECT = 24'h528585
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [7:0]  req_byte,
  input  logic [2:0]  req_len,
  input  logic        reads_off,
  input  logic [23:0] id_bytes,
  output logic        req_ready,
  output logic        done,
  output logic        err,
  output logic        id_ok,
  output logic        cs_n,
  output logic        sclk,
  output logic        sd_out,
  output logic        sd_oe,
  output logic        run,
  output logic        rx_clear,
  output logic        rx_en,
  output logic [2:0]  rd_len
);
  localparam int BW = $clog2(WORD_W * (RX_BYTES + 1));

  link_state_e       state_q, state_d;
  req_kind_e         kind_q, kind_d;
  logic              hi_q, hi_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [BW-1:0]     last_q, last_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [2:0]        len_q, len_d;
  logic              err_q, err_d;
  logic              idok_q, idok_d;

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    hi_d     = hi_q;
    bit_d    = bit_q;
    last_d   = last_q;
    tx_d     = tx_q;
    len_d    = len_q;
    err_d    = err_q;
    idok_d   = idok_q;
    rx_clear = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          kind_d = req_kind_e'(req_kind);
          err_d  = 1'b0;
          idok_d = 1'b0;
          hi_d   = 1'b0;
          bit_d  = '0;
          unique case (req_kind_e'(req_kind))
            K_CMD, K_DAT: begin
              tx_d    = {req_kind[0], req_byte};
              last_d  = BW'(WORD_W - 1);
              state_d = S_SHIFT;
            end
            K_READ: begin
              if (reads_off || !len_legal(req_len)) begin
                err_d   = 1'b1;
                state_d = S_FIN;
              end else begin
                tx_d     = {1'b0, req_byte};
                len_d    = req_len;
                last_d   = BW'(WORD_W) * BW'(req_len) + BW'(WORD_W - 1);
                rx_clear = 1'b1;
                state_d  = S_SHIFT;
              end
            end
            default: begin
              if (reads_off) begin
                idok_d  = 1'b1;
                state_d = S_FIN;
              end else begin
                tx_d     = {1'b0, ID_CMD};
                len_d    = 3'd3;
                last_d   = BW'(WORD_W * 4 - 1);
                rx_clear = 1'b1;
                state_d  = S_SHIFT;
              end
            end
          endcase
        end
      end
      S_SHIFT: begin
        if (tick) begin
          if (!hi_q) begin
            hi_d = 1'b1;
          end else begin
            hi_d = 1'b0;
            if (bit_q == last_q) begin
              bit_d   = '0;
              state_d = S_GAP;
            end else begin
              bit_d = bit_q + 1'b1;
              tx_d  = {tx_q[WORD_W-2:0], 1'b0};
            end
          end
        end
      end
      S_GAP: begin
        if (tick) begin
          if (!hi_q) begin
            hi_d = 1'b1;
          end else begin
            hi_d    = 1'b0;
            state_d = S_FIN;
            if (kind_q == K_ID) idok_d = (id_bytes == ID_EXPECT);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_CMD;
      hi_q    <= 1'b0;
      bit_q   <= '0;
      last_q  <= '0;
      tx_q    <= '0;
      len_q   <= '0;
      err_q   <= 1'b0;
      idok_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      hi_q    <= hi_d;
      bit_q   <= bit_d;
      last_q  <= last_d;
      tx_q    <= tx_d;
      len_q   <= len_d;
      err_q   <= err_d;
      idok_q  <= idok_d;
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign done      = (state_q == S_FIN);
  assign err       = err_q;
  assign id_ok     = idok_q;
  assign cs_n      = (state_q != S_SHIFT);
  assign sclk      = (state_q == S_SHIFT) && hi_q;
  assign sd_oe     = (state_q == S_SHIFT) && (bit_q < BW'(WORD_W));
  assign sd_out    = sd_oe && tx_q[WORD_W-1];
  assign run       = (state_q == S_SHIFT) || (state_q == S_GAP);
  assign rx_en     = (state_q == S_SHIFT) && tick && !hi_q && (bit_q >= BW'(WORD_W));
  assign rd_len    = len_q;
endmodule

// File: rtl/nine_bit_panel_link.sv
module nine_bit_panel_link
  import nbl_pkg::*;
#(
  parameter int          DIV_HALF  = 2,
  parameter logic [7:0]  ID_CMD    = 8'h04,
  parameter logic [23:0] ID_EXPECT = 24'h528585
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_kind,
  input  logic [7:0]            req_byte,
  input  logic [2:0]            req_len,
  input  logic                  reads_off,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  sd_out,
  output logic                  sd_oe,
  input  logic                  sd_in,
  output logic [8*RX_BYTES-1:0] rd_data,
  output logic                  done,
  output logic                  err,
  output logic                  id_ok
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic                       tick, run, rx_clear, rx_en;
  logic [2:0]                 rd_len;
  logic [WORD_W*RX_BYTES-1:0] words;
  logic [8*RX_BYTES-1:0]      bytes;

  nbl_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk   (clk),
    .rst_n (core_rst_n),
    .run   (run),
    .tick  (tick)
  );

  nbl_ctrl #(.ID_CMD(ID_CMD), .ID_EXPECT(ID_EXPECT)) u_ctrl (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick      (tick),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_byte  (req_byte),
    .req_len   (req_len),
    .reads_off (reads_off),
    .id_bytes  (bytes[23:0]),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .id_ok     (id_ok),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sd_out    (sd_out),
    .sd_oe     (sd_oe),
    .run       (run),
    .rx_clear  (rx_clear),
    .rx_en     (rx_en),
    .rd_len    (rd_len)
  );

  nbl_rx_capture u_cap (
    .clk   (clk),
    .rst_n (core_rst_n),
    .clear (rx_clear),
    .en    (rx_en),
    .sd_in (sd_in),
    .words (words)
  );

  nbl_rx_align u_align (
    .words (words),
    .len   (rd_len),
    .bytes (bytes)
  );

  assign rd_data = bytes;
endmodule

// File: rtl/nbl_checker.sv
module nbl_checker #(
  parameter int DIV_HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic sd_out,
  input logic sd_oe,
  input logic req_ready,
  input logic done
);
  localparam int GAPMIN = 2 * DIV_HALF;
  localparam int GW     = $clog2(GAPMIN + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= GW'(GAPMIN);
    else if (!cs_n)                 gap_q <= '0;
    else if (gap_q < GW'(GAPMIN))   gap_q <= gap_q + 1'b1;
  end

  assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_data_hold_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && sclk) |-> $stable(sd_out));

  assert_pad_stays_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$past(sd_oe)) |-> !sd_oe);

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_select_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gap_q >= GW'(GAPMIN)));
endmodule

bind nine_bit_panel_link nbl_checker #(.DIV_HALF(DIV_HALF)) u_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .sd_out    (sd_out),
  .sd_oe     (sd_oe),
  .req_ready (req_ready),
  .done      (done)
);

// File: tb/sim_nine_bit_panel_link.sv
module sim_nine_bit_panel_link;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, reads_off;
  logic [1:0]  req_kind;
  logic [7:0]  req_byte;
  logic [2:0]  req_len;
  logic        cs_n, sclk, sd_out, sd_oe, sd_in;
  logic [31:0] rd_data;
  logic        done, err, id_ok;

  always #4 clk = ~clk;

  nine_bit_panel_link #(.DIV_HALF(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_byte(req_byte), .req_len(req_len), .reads_off(reads_off),
    .cs_n(cs_n), .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
    .rd_data(rd_data), .done(done), .err(err), .id_ok(id_ok)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Panel model and bus monitor
  int          rise_cnt = 0;
  int          tx_nb = 0;
  logic [8:0]  tx_cap = '0;
  logic [63:0] rx_stream = '0;
  int          win_rises = 0, win_nb = 0, cs_falls = 0;
  logic [8:0]  win_cap = '0;

  assign sd_in = (rise_cnt >= 9 && rise_cnt < 73) ? rx_stream[72 - rise_cnt] : 1'b0;

  always @(posedge sclk or negedge cs_n) begin
    if (!sclk) begin
      rise_cnt = 0; tx_cap = '0; tx_nb = 0;
    end else begin
      if (sd_oe) begin tx_cap = {tx_cap[7:0], sd_out}; tx_nb++; end
      rise_cnt++;
    end
  end

  always @(posedge cs_n) begin
    win_rises = rise_cnt; win_cap = tx_cap; win_nb = tx_nb;
  end

  always @(negedge cs_n) cs_falls++;

  logic prev_sclk = 1'b0, prev_out = 1'b0, had_win = 1'b0;
  int   hold_viol = 0, oe_viol = 0, hi_len = 0, hi_bad = 0, gap_len = 0, min_gap = 1000;

  always @(negedge clk) begin
    if (sclk && prev_sclk && sd_out !== prev_out) hold_viol++;
    if (!cs_n && rise_cnt >= 10 && sd_oe) oe_viol++;
    if (sclk) hi_len++;
    else begin
      if (prev_sclk && hi_len != DIV) hi_bad++;
      hi_len = 0;
    end
    if (cs_n === 1'b1) gap_len++;
    else if (cs_n === 1'b0) begin
      if (had_win && gap_len > 0 && gap_len < min_gap) min_gap = gap_len;
      had_win = 1'b1;
      gap_len = 0;
    end
    prev_sclk = sclk;
    prev_out  = sd_out;
  end

  task automatic issue(input logic [1:0] k, input logic [7:0] b, input logic [2:0] n);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_byte = b; req_len = n;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (done !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    check({req, " done strobe"}, 32'(done), 32'd1);
    @(negedge clk);
    check({req, " done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b00; req_byte = 8'h00;
    req_len = 3'd0; reads_off = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 cs_n after reset", 32'(cs_n), 32'd1);
    check("R9 sclk after reset", 32'(sclk), 32'd0);
    check("R9 ready after reset", 32'(req_ready), 32'd1);
    check("R9 done after reset", 32'(done), 32'd0);
  endtask

  task automatic t_write(input logic [1:0] k, input logic [7:0] b, input logic [8:0] exp);
    int f0 = cs_falls;
    issue(k, b, 3'd0);
    wait_done("R1 write");
    check("R1 write word", 32'(win_cap), 32'(exp));
    check("R1 write bit count", 32'(win_nb), 32'd9);
    check("R1 write clock count", 32'(win_rises), 32'd9);
    check("R1 one select window", 32'(cs_falls - f0), 32'd1);
  endtask

  task automatic t_read(input logic [2:0] n, input logic [7:0] cmd, input logic [31:0] bytes_in);
    logic [31:0] mask;
    int f0 = cs_falls;
    rx_stream = {1'b1, bytes_in[7:0], bytes_in[15:8], bytes_in[23:16], bytes_in[31:24], 31'h7fffffff};
    mask = (n == 3'd1) ? 32'h000000ff : (n == 3'd3) ? 32'h00ffffff : 32'hffffffff;
    issue(2'b10, cmd, n);
    wait_done("R3 read");
    check("R3 read command word", 32'(win_cap), {23'd0, 1'b0, cmd});
    check("R3 read clock count", 32'(win_rises), 32'(9 + 9 * int'(n)));
    check("R3 one select window", 32'(cs_falls - f0), 32'd1);
    check("R4 realigned bytes", rd_data, bytes_in & mask);
    check("R5 no error on legal length", 32'(err), 32'd0);
  endtask

  task automatic t_bad_len(input logic [2:0] n);
    int f0 = cs_falls;
    issue(2'b10, 8'h0a, n);
    wait_done("R5 bad length");
    check("R5 error flag", 32'(err), 32'd1);
    check("R5 no select activity", 32'(cs_falls - f0), 32'd0);
  endtask

  task automatic t_id(input logic [23:0] reply, input logic exp);
    int f0 = cs_falls;
    rx_stream = {1'b1, reply[7:0], reply[15:8], reply[23:16], 8'h00, 31'h7fffffff};
    issue(2'b11, 8'hff, 3'd0);
    wait_done("R6 id check");
    check("R6 id command word", 32'(win_cap), 32'h004);
    check("R6 id clock count", 32'(win_rises), 32'd36);
    check("R6 id result", 32'(id_ok), 32'(exp));
    check("R6 one select window", 32'(cs_falls - f0), 32'd1);
  endtask

  task automatic t_reads_off();
    int f0 = cs_falls;
    reads_off = 1'b1;
    issue(2'b11, 8'h00, 3'd0);
    wait_done("R7 id with reads off");
    check("R7 id reports success", 32'(id_ok), 32'd1);
    check("R7 id no error", 32'(err), 32'd0);
    issue(2'b10, 8'h0a, 3'd1);
    wait_done("R7 read with reads off");
    check("R7 read rejected", 32'(err), 32'd1);
    check("R7 no select activity", 32'(cs_falls - f0), 32'd0);
    reads_off = 1'b0;
  endtask

  task automatic t_held_valid();
    int f0 = cs_falls;
    int ready_bad = 0;
    int t = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_byte = 8'h5a; req_len = 3'd0;
    @(negedge clk);
    while (done !== 1'b1 && t < 3000) begin
      if (!cs_n && req_ready) ready_bad++;
      @(negedge clk); t++;
    end
    req_valid = 1'b0;
    check("R8 done with pending valid", 32'(done), 32'd1);
    check("R8 ready low while selected", 32'(ready_bad), 32'd0);
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 32'd0);
    repeat (4 * DIV + 4) @(negedge clk);
    check("R8 held valid gives one window", 32'(cs_falls - f0), 32'd1);
    issue(2'b01, 8'h11, 3'd0);
    issue(2'b01, 8'h22, 3'd0);
    wait_done("R8 back to back");
    check("R1 back to back last word", 32'(win_cap), 32'h122);
    check("R8 select gap", 32'(min_gap >= 2 * DIV), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_write(2'b00, 8'h3a, 9'h03a);
    t_write(2'b01, 8'hc5, 9'h1c5);
    t_read(3'd1, 8'h0a, 32'h000000a5);
    t_read(3'd3, 8'h0b, 32'h00563412);
    t_read(3'd4, 8'h0c, 32'hefbeadde);
    t_bad_len(3'd2);
    t_bad_len(3'd0);
    t_bad_len(3'd5);
    t_id(24'h528585, 1'b1);
    t_id(24'h538585, 1'b0);
    t_reads_off();
    t_held_valid();
    check("R2 data stable while clock high", 32'(hold_viol), 32'd0);
    check("R2 high phase length", 32'(hi_bad), 32'd0);
    check("R3 pad released during reply", 32'(oe_viol), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule